// File: doc/BRIEF.md
# UART Receive Character Queue

This block sits behind a serial deserializer and stores received characters until software reads them. Every stored entry keeps the data byte together with its own break, parity-error and frame-error flags, so the error status that software sees always belongs to the character it has just taken. Entries leave in arrival order through a read strobe. The strobe pops the head entry into a registered read word.

Three receive conditions are reported, each with its own status bit and its own enable bit. The first is an overrun: a character arrived while all slots were taken and was discarded. The second is a fill level above a programmable threshold. The third is a queue that has held data for a programmable number of character times with no push or pop. The interrupt line is the OR of the enabled conditions. The overrun indication is sticky, and only the queue-clear control removes it. The clear control also discards every stored entry.

A character-time tick comes from the baud logic outside this block, and the timeout is counted in those ticks.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the level is 0, `not_empty` is 0, `stat` is 0, `irq` is 0 and `rd_word` is all zeros.
- R2: Characters are read back in arrival order. A popped word holds the data byte in bits 7:0, a 1 in bit 8 (valid), the break flag in bit 9, the parity-error flag in bit 10 and the frame-error flag in bit 11, each flag as it was given with that character. The word appears on `rd_word` the cycle after `rd_en`.
- R3: A read strobe while the queue is empty loads an all-zero word (valid bit 0) and leaves the level at 0.
- R4: The queue holds 16 characters. A character that arrives while 16 are held and no pop happens in that cycle is dropped, the level stays 16, and overrun status `stat[0]` becomes 1.
- R5: `stat[0]` stays 1 across reads. Only a `q_clear` pulse clears it. That pulse also empties the queue, so afterwards the level is 0, `stat` is 0 and a read returns an all-zero word.
- R6: Threshold status `stat[1]` is 1 exactly when the level is greater than `lvl_thresh`.
- R7: Timeout status `stat[2]` is 1 when the queue is non-empty and at least `tmo_chars` pulses of `char_tick` have occurred since the last push or pop. The counter restarts on every push or pop. A `tmo_chars` value of 0 disables the condition. `stat[2]` is 0 whenever the queue is empty.
- R8: `irq` is 1 exactly when some bit of `stat` is 1 together with the same bit of `irq_en`. Every `stat` bit is visible whatever the value of `irq_en`.
- R9: `not_empty` is 1 exactly when the level is non-zero.
- R10: When a character arrives and a pop happens in the same cycle while the queue is full, both take effect, the level stays 16 and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_stb | input | 1 | One-cycle strobe: a character is complete |
| rx_data | input | 8 | Received data byte |
| rx_brk | input | 1 | Break detected on this character |
| rx_par | input | 1 | Parity error on this character |
| rx_frm | input | 1 | Frame error on this character |
| char_tick | input | 1 | One pulse per character time |
| rd_en | input | 1 | Pop the head entry into `rd_word` |
| q_clear | input | 1 | Discard all entries and clear the overrun status |
| lvl_thresh | input | 5 | Fill level threshold |
| tmo_chars | input | 4 | Timeout in character times, 0 disables |
| irq_en | input | 3 | Enable bits for {timeout, threshold, overrun} |
| rd_word | output | 12 | Last popped word |
| level | output | 5 | Number of stored entries |
| not_empty | output | 1 | At least one entry is stored |
| stat | output | 3 | Status bits {timeout, threshold, overrun} |
| irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that `rx_stb`, `rd_en`, `q_clear` and `char_tick` are single-cycle strobes that are sampled synchronously. They also assume that `q_clear` does not coincide with a read whose result matters. The bench drives every strobe on the falling edge for exactly one cycle and never combines a clear with a read. It holds `lvl_thresh` and `tmo_chars` steady while characters are queued, so each status bit follows from the level and tick history alone.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       frm;
    logic       par;
    logic       brk;
    logic [7:0] data;
  } rxq_entry_t;

  localparam int WORD_W = 12;

  // Bits 7:0 data, 8 valid, 9 break, 10 parity, 11 frame.
  function automatic logic [WORD_W-1:0] pack_word(input rxq_entry_t e);
    return {e.frm, e.par, e.brk, 1'b1, e.data};
  endfunction

  function automatic logic level_above(input logic [4:0] lvl, input logic [4:0] thr);
    return lvl > thr;
  endfunction

  function automatic logic tmo_hit(input logic [3:0] cnt, input logic [3:0] lim);
    return (lim != 4'd0) && (cnt >= lim);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  rxq_entry_t    push_ent,
  input  logic          pop,
  output rxq_entry_t    head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          do_push,
  output logic          do_pop,
  output logic          drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty && !clr;
  assign do_push = push && !clr && (!full || do_pop);
  assign drop    = push && !clr && full && !do_pop;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_drop_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (count == CW'(DEPTH)));

  p_clear_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  p_swap_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop && !clr) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
  import rxq_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          restart,
  input  logic          held,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt <= '0;
    else if (clr || restart || !held)      cnt <= '0;
    else if (tick && (cnt != {TW{1'b1}}))  cnt <= cnt + TW'(1);
  end

  assign expired = held && tmo_hit(cnt, limit);

  p_tmo_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || clr) |=> (cnt == '0));

endmodule

// File: rtl/rxq_cause.sv
module rxq_cause
  import rxq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          drop,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] thresh,
  input  logic          tmo,
  input  logic [2:0]    en,
  output logic [2:0]    stat,
  output logic          irq
);
  logic ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ovr <= 1'b0;
    else if (clr)  ovr <= 1'b0;
    else if (drop) ovr <= 1'b1;
  end

  assign stat = {tmo, level_above(count, thresh), ovr};
  assign irq  = |(stat & en);

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovr);

  p_ovr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr) |=> ovr);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_stb,
  input  logic [7:0]        rx_data,
  input  logic              rx_brk,
  input  logic              rx_par,
  input  logic              rx_frm,
  input  logic              char_tick,
  input  logic              rd_en,
  input  logic              q_clear,
  input  logic [CW-1:0]     lvl_thresh,
  input  logic [TW-1:0]     tmo_chars,
  input  logic [2:0]        irq_en,
  output logic [WORD_W-1:0] rd_word,
  output logic [CW-1:0]     level,
  output logic              not_empty,
  output logic [2:0]        stat,
  output logic              irq
);
  rxq_entry_t in_ent, head;
  logic       empty, full, do_push, do_pop, drop, tmo_w;

  assign in_ent = '{frm: rx_frm, par: rx_par, brk: rx_brk, data: rx_data};

  rxq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(q_clear),
    .push(rx_stb), .push_ent(in_ent), .pop(rd_en),
    .head(head), .count(level), .empty(empty), .full(full),
    .do_push(do_push), .do_pop(do_pop), .drop(drop)
  );

  rxq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(q_clear),
    .restart(do_push || do_pop), .held(!empty),
    .tick(char_tick), .limit(tmo_chars), .expired(tmo_w)
  );

  rxq_cause #(.CW(CW)) u_cause (
    .clk(clk), .rst_n(rst_n), .clr(q_clear), .drop(drop),
    .count(level), .thresh(lvl_thresh), .tmo(tmo_w), .en(irq_en),
    .stat(stat), .irq(irq)
  );

  assign not_empty = !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_word <= '0;
    else if (rd_en)  rd_word <= do_pop ? pack_word(head) : '0;
  end

  p_rd_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (level == '0)) |=> (rd_word == '0));

  p_tmo_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !stat[2]);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != 3'b000));

  p_full_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> not_empty);

endmodule

// File: tb/uart_rx_queue_test.sv
`timescale 1ns/1ps
module uart_rx_queue_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rx_stb = 0, rx_brk = 0, rx_par = 0, rx_frm = 0, char_tick = 0;
  logic        rd_en = 0, q_clear = 0;
  logic [7:0]  rx_data = 0;
  logic [4:0]  lvl_thresh = 5'd31;
  logic [3:0]  tmo_chars = 0;
  logic [2:0]  irq_en = 0;
  logic [11:0] rd_word;
  logic [4:0]  level;
  logic        not_empty, irq;
  logic [2:0]  stat;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [11:0] mq[$];

  always #2.5 clk = ~clk;

  uart_rx_queue uut (
    .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_data(rx_data),
    .rx_brk(rx_brk), .rx_par(rx_par), .rx_frm(rx_frm), .char_tick(char_tick),
    .rd_en(rd_en), .q_clear(q_clear), .lvl_thresh(lvl_thresh),
    .tmo_chars(tmo_chars), .irq_en(irq_en), .rd_word(rd_word),
    .level(level), .not_empty(not_empty), .stat(stat), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares each popped word against the scoreboard head.
  always @(posedge clk) begin
    if (rd_en && rst_n) begin
      logic [11:0] exp;
      string tag;
      if (mq.size() > 0) begin exp = mq.pop_front(); tag = "R2 read order/format"; end
      else begin exp = 12'h000; tag = "R3 empty read"; end
      #1;
      chk(tag, rd_word, exp);
    end
  end

  function automatic logic [11:0] mk(input logic [7:0] d, input logic b, p, f);
    return {f, p, b, 1'b1, d};
  endfunction

  task automatic send(input logic [7:0] d, input logic b, p, f, input bit with_rd = 0);
    @(negedge clk);
    rx_stb = 1; rx_data = d; rx_brk = b; rx_par = p; rx_frm = f; rd_en = with_rd;
    if (mq.size() < 16 || with_rd) mq.push_back(mk(d, b, p, f));
    @(negedge clk);
    rx_stb = 0; rd_en = 0; rx_brk = 0; rx_par = 0; rx_frm = 0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic tick();
    @(negedge clk); char_tick = 1;
    @(negedge clk); char_tick = 0;
  endtask

  task automatic clear();
    @(negedge clk); q_clear = 1;
    @(negedge clk); q_clear = 0;
    mq.delete();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 level", level, 0);
    chk("R1 not_empty", not_empty, 0);
    chk("R1 stat", stat, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_word", rd_word, 0);

    rd();                                  // R3: empty read
    chk("R3 level after empty read", level, 0);

    send(8'hA5, 0, 0, 0);
    send(8'h3C, 1, 0, 0);
    send(8'h7E, 0, 1, 1);
    chk("R9 not_empty", not_empty, 1);
    chk("R2 level three", level, 3);
    repeat (3) rd();
    chk("R9 not_empty drained", not_empty, 0);

    // R6 / R8 threshold
    lvl_thresh = 5'd4;
    for (int i = 0; i < 4; i++) send(8'(8'h10 + i), 0, 0, 0);
    chk("R6 level equal threshold", stat[1], 0);
    send(8'h14, 0, 1, 0);
    chk("R6 level above threshold", stat[1], 1);
    chk("R8 masked irq", irq, 0);
    irq_en = 3'b010;
    #1 chk("R8 enabled irq", irq, 1);
    irq_en = 3'b000;

    // R4 fill and overrun
    for (int i = 5; i < 16; i++) send(8'(8'h10 + i), i[0], 0, i[1]);
    chk("R4 full level", level, 16);
    chk("R4 no overrun yet", stat[0], 0);
    send(8'hEE, 0, 0, 0);
    chk("R4 dropped level", level, 16);
    chk("R4 overrun set", stat[0], 1);
    chk("R8 overrun masked irq", irq, 0);
    irq_en = 3'b001;
    #1 chk("R8 overrun irq", irq, 1);
    irq_en = 3'b000;
    rd(); rd();
    chk("R5 overrun sticky", stat[0], 1);
    clear();
    chk("R5 level cleared", level, 0);
    chk("R5 stat cleared", stat, 0);
    rd();

    // R10 swap while full
    for (int i = 0; i < 16; i++) send(8'(8'h40 + i), 0, 0, 0);
    send(8'h99, 1, 1, 1, 1);
    chk("R10 level stays full", level, 16);
    chk("R10 no overrun", stat[0], 0);
    repeat (16) rd();
    chk("R10 drained", level, 0);

    // R7 timeout
    lvl_thresh = 5'd31;
    tmo_chars = 4'd2;
    send(8'h55, 0, 0, 0);
    tick();
    chk("R7 one tick", stat[2], 0);
    tick();
    chk("R7 expired", stat[2], 1);
    irq_en = 3'b100;
    #1 chk("R8 timeout irq", irq, 1);
    send(8'h56, 0, 0, 0);
    chk("R7 restart on push", stat[2], 0);
    tick(); tick();
    chk("R7 expired again", stat[2], 1);
    rd();
    chk("R7 restart on pop", stat[2], 0);
    rd();
    tick(); tick(); tick();
    chk("R7 empty no timeout", stat[2], 0);
    tmo_chars = 4'd0;
    send(8'h57, 0, 0, 0);
    repeat (5) tick();
    chk("R7 disabled", stat[2], 0);
    chk("R8 no cause no irq", irq, 0);
    rd();
    rd();

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule